// File: doc/BRIEF.md
# Tagged ADC Result FIFO with Split-Width Readout

This block holds converted analog samples until software or a bulk-transfer engine collects them. A conversion sequencer pushes two tagged results at once. Each result is a 30-bit tag word that holds a 16-bit two's-complement sample, the gain code, the channel number, the input-mode flags and a snapshot of two digital pins. The pair is stored as one 60-bit entry, and the occupancy count is kept in entries, which is the same as pairs of conversions.

The block has two read ports. The first is 32 bits wide and is meant for register access. It returns the lower word of the head entry on one request and the upper word on the next request. The entry leaves the FIFO only after the upper word has been read. The second port is 64 bits wide and returns the whole head entry in one beat. On both ports, bit 31 of every word is an invalid flag and bit 30 is the live state of the sequencer-running input.

A read of an empty FIFO returns the invalid flag instead of stale data. A push that arrives while the FIFO is full is discarded and raises a sticky overflow flag. An almost-full flag compares the count against a level supplied on an input.

Top module: `adc_tag_fifo`

## Requirements
- R1: After reset the FIFO is empty. The count, rd_data, dma_data, full and overflow are all zero, and the next 32-bit read targets a lower word.
- R2: A 32-bit read of a non-empty FIFO returns the head entry's lower tag (wr_lo) in bits 29:0 with bit 31 clear. The next 32-bit read returns the upper tag (wr_hi). The count drops by one only on the edge that serves the upper read. rd_data updates on the clock edge that samples rd_req.
- R3: count equals the number of stored entries. An accepted push adds one, a pop removes one, and an accepted push together with a pop leaves the count unchanged. count never exceeds DEPTH.
- R4: A 32-bit read while count is zero returns bit 31 = 1, bit 30 = seq_running, and bits 29:0 = 0. It changes neither the count nor the half-read position.
- R5: Bit 30 of every word returned on either port equals seq_running in the cycle the read was requested.
- R6: Tag fields pass through unchanged. They are the result in bits 15:0, the gain in 18:16, the differential flag in 19, the channel in 22:20, the channel-high bit in 23, the auxiliary-input flag in 24, the temperature flag in 25, and the pin snapshots in 26 (pin 0) and 27 (pin 1). Bits 29:28 are carried as written.
- R7: A 64-bit read returns {upper word, lower word}, each formatted as in R2/R5, and pops the entry. If a lower word has already been read through the 32-bit port, the 64-bit read still pops the entry and resets the 32-bit port to the lower word. A 64-bit read when empty sets bits 63 and 31.
- R8: When rd_req and dma_req are high in the same cycle, only the 32-bit read is served and dma_data keeps its value.
- R9: A push while full (count = DEPTH before the edge) is dropped even if a pop happens in the same cycle. It sets overflow, which stays high until reset.
- R10: almost_full is high exactly when count >= afull_level.
- R11: Entries leave in the order they were pushed, including after the storage pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Push a pair of tagged results |
| wr_lo | input | 30 | First tag of the pair (lower word) |
| wr_hi | input | 30 | Second tag of the pair (upper word) |
| seq_running | input | 1 | Sequencer running, reported in bit 30 |
| afull_level | input | CNT_W | Almost-full threshold in entries |
| rd_req | input | 1 | 32-bit read request |
| rd_data | output | 32 | 32-bit read result |
| dma_req | input | 1 | 64-bit read request |
| dma_data | output | 64 | 64-bit read result |
| count | output | CNT_W | Stored entries (pairs of conversions) |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count is DEPTH |
| almost_full | output | 1 | Count at or above afull_level |
| overflow | output | 1 | Sticky: a push was dropped |

## Verification
The bench first runs directed patterns.
- Lower-then-upper reads show whether the pop happens on the upper read or too early.
- A lower read followed by a 64-bit read shows whether the half position is reset.
- Reads of an empty FIFO with the running input at 0 and at 1 separate the invalid format from stale data.
- A push into a full FIFO with a pop in the same cycle shows whether fullness is judged before the pop.
- A tag with every field set to a distinct value exposes any swapped field.

A long random mix of pushes, reads on both ports and simultaneous requests then wraps the pointers many times against a queue model. This catches ordering and count errors that the directed patterns do not reach.

// File: rtl/adc_tag_pkg.sv
package adc_tag_pkg;
   localparam int TAG_W   = 30;
   localparam int WORD_W  = 32;
   localparam int ENTRY_W = 2 * TAG_W;
   localparam int INV_BIT = 31;
   localparam int RUN_BIT = 30;

   typedef struct packed {
      logic [TAG_W-1:0] hi;
      logic [TAG_W-1:0] lo;
   } entry_t;

   function automatic logic [WORD_W-1:0] fmt_word(input logic is_empty,
                                                  input logic run,
                                                  input logic [TAG_W-1:0] tag);
      if (is_empty) fmt_word = {1'b1, run, {TAG_W{1'b0}}};
      else          fmt_word = {1'b0, run, tag};
   endfunction
endpackage

// File: rtl/adc_tag_store.sv
module adc_tag_store
   import adc_tag_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  entry_t           push_data,
   input  logic             pop,
   output entry_t           head,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             full,
   output logic             overflow
);
   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_chk
      $error("adc_tag_store: DEPTH must be a power of two of at least 2");
   end
   if (CNT_W < $clog2(DEPTH + 1)) begin : g_cnt_chk
      $error("adc_tag_store: CNT_W too narrow for DEPTH");
   end

   entry_t           mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push && full) overflow <= 1'b1;
      end
   end

   // R3: occupancy bounded by the depth
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   // R3: accepted push with pop keeps the count
   a_r3_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop && !full && !empty |=> count == $past(count));
   // R9: a push into a full store leaves it full when nothing pops
   a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      push && full && !pop |=> full);
   // R9: overflow is sticky
   a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
endmodule

// File: rtl/adc_tag_rdsel.sv
module adc_tag_rdsel
   import adc_tag_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_req,
   input  logic                  dma_req,
   input  logic                  running,
   input  logic                  empty,
   input  entry_t                head,
   output logic                  pop,
   output logic [WORD_W-1:0]     rd_data,
   output logic [2*WORD_W-1:0]   dma_data
);
   logic                   half_hi;
   logic                   dma_go;
   logic [1:0][TAG_W-1:0]  tags;
   logic [1:0][WORD_W-1:0] fmt;

   assign tags   = {head.hi, head.lo};
   assign dma_go = dma_req && !rd_req;

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign fmt[h] = fmt_word(empty, running, tags[h]);
   end

   assign pop = !empty && ((rd_req && half_hi) || dma_go);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_hi  <= 1'b0;
         rd_data  <= '0;
         dma_data <= '0;
      end else if (rd_req) begin
         rd_data <= fmt[half_hi];
         if (!empty) half_hi <= !half_hi;
      end else if (dma_go) begin
         dma_data <= {fmt[1], fmt[0]};
         half_hi  <= 1'b0;
      end
   end

   // R4: empty 32-bit read is flagged invalid
   a_r4_empty_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && empty |=> rd_data[INV_BIT] && rd_data[TAG_W-1:0] == '0);
   // R5: running bit follows the input at request time
   a_r5_run_bit: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_data[RUN_BIT] == $past(running));
   // R7: empty 64-bit read flags both halves
   a_r7_dma_empty: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !rd_req && empty |=> dma_data[WORD_W+INV_BIT] && dma_data[INV_BIT]);
   // R8: the 32-bit port wins, 64-bit output holds
   a_r8_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && dma_req |=> $stable(dma_data));
endmodule

// File: rtl/adc_tag_fifo.sv
module adc_tag_fifo
   import adc_tag_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic [29:0]      wr_lo,
   input  logic [29:0]      wr_hi,
   input  logic             seq_running,
   input  logic [CNT_W-1:0] afull_level,
   input  logic             rd_req,
   output logic [31:0]      rd_data,
   input  logic             dma_req,
   output logic [63:0]      dma_data,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             full,
   output logic             almost_full,
   output logic             overflow
);
   entry_t head;
   logic   pop;

   adc_tag_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_valid),
      .push_data ({wr_hi, wr_lo}),
      .pop       (pop),
      .head      (head),
      .count     (count),
      .empty     (empty),
      .full      (full),
      .overflow  (overflow)
   );

   adc_tag_rdsel u_rdsel (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .dma_req  (dma_req),
      .running  (seq_running),
      .empty    (empty),
      .head     (head),
      .pop      (pop),
      .rd_data  (rd_data),
      .dma_data (dma_data)
   );

   assign almost_full = (count >= afull_level);

   // R2: a lower-half read without a push leaves the count alone
   a_r2_lower_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !empty && !wr_valid && !pop |=> count == $past(count));
   // R10: almost-full tracks the threshold
   a_r10_afull: assert property (@(posedge clk) disable iff (!rst_n)
      full && afull_level <= CNT_W'(DEPTH) |-> almost_full);
endmodule

// File: tb/adc_tag_fifo_tb.sv
module adc_tag_fifo_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int CNT_W      = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_valid = 1'b0;
   logic [29:0]      wr_lo = '0, wr_hi = '0;
   logic             seq_running = 1'b0;
   logic [CNT_W-1:0] afull_level = CNT_W'(DEPTH);
   logic             rd_req = 1'b0, dma_req = 1'b0;
   logic [31:0]      rd_data;
   logic [63:0]      dma_data;
   logic [CNT_W-1:0] count;
   logic             empty, full, almost_full, overflow;

   adc_tag_fifo #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .seq_running(seq_running), .afull_level(afull_level), .rd_req(rd_req),
      .rd_data(rd_data), .dma_req(dma_req), .dma_data(dma_data), .count(count),
      .empty(empty), .full(full), .almost_full(almost_full), .overflow(overflow));

   always #(CLK_PERIOD/2) clk = ~clk;

   int          n_tests = 0;
   int          n_fail  = 0;
   bit          done    = 1'b0;
   logic [59:0] q[$];
   logic        m_half = 1'b0;
   logic        m_ovf  = 1'b0;
   logic [31:0] exp_rd  = '0;
   logic [63:0] exp_dma = '0;
   string       ok_tag  = "R2";

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [29:0] mk_tag(input logic [15:0] res, input logic [2:0] gain,
         input logic diff, input logic [2:0] ch, input logic seqb, input logic aux,
         input logic temp, input logic d0, input logic d1);
      return {2'b00, d1, d0, temp, aux, seqb, ch, diff, gain, res};
   endfunction

   task automatic cyc(input logic p, input logic [29:0] lo, input logic [29:0] hi,
                      input logic r, input logic d, input logic run);
      int    pre;
      string rtag;
      pre  = q.size();
      rtag = ok_tag;
      wr_valid = p; wr_lo = lo; wr_hi = hi; rd_req = r; dma_req = d; seq_running = run;
      if (r) begin
         if (pre == 0) begin
            exp_rd = {1'b1, run, 30'd0};
            rtag = "R4";
         end else if (!m_half) begin
            exp_rd = {1'b0, run, q[0][29:0]};
            m_half = 1'b1;
         end else begin
            exp_rd = {1'b0, run, q[0][59:30]};
            void'(q.pop_front());
            m_half = 1'b0;
         end
      end else if (d) begin
         if (pre == 0) exp_dma = {1'b1, run, 30'd0, 1'b1, run, 30'd0};
         else begin
            exp_dma = {1'b0, run, q[0][59:30], 1'b0, run, q[0][29:0]};
            void'(q.pop_front());
         end
         m_half = 1'b0;
      end
      if (p) begin
         if (pre >= DEPTH) m_ovf = 1'b1;
         else q.push_back({hi, lo});
      end
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0; rd_req = 1'b0; dma_req = 1'b0;
      chk("R3 count", 64'(count), 64'(q.size()));
      chk("R3 empty", 64'(empty), 64'(q.size() == 0));
      chk("R9 full", 64'(full), 64'(q.size() == DEPTH));
      chk("R9 overflow", 64'(overflow), 64'(m_ovf));
      chk("R10 almost_full", 64'(almost_full), 64'(q.size() >= int'(afull_level)));
      chk({rtag, " rd_data"}, 64'(rd_data), 64'(exp_rd));
      chk("R7 dma_data", dma_data, exp_dma);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [29:0] t6;
      logic [63:0] dma_before;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 count", 64'(count), 64'd0);
      chk("R1 empty", 64'(empty), 64'd1);
      chk("R1 full/ovf", 64'({full, overflow}), 64'd0);
      chk("R1 rd_data", 64'(rd_data), 64'd0);
      chk("R1 dma_data", dma_data, 64'd0);

      // R6: distinct field values
      t6 = mk_tag(16'h8123, 3'd5, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      cyc(1, t6, 30'h2AAA_5555, 0, 0, 1);
      cyc(1, 30'h0000_1111, 30'h0000_2222, 0, 0, 1);
      cyc(1, 30'h0000_3333, 30'h0000_4444, 0, 0, 1);
      cyc(0, '0, '0, 1, 0, 1);
      chk("R6 result", 64'(rd_data[15:0]), 64'h8123);
      chk("R6 gain", 64'(rd_data[18:16]), 64'd5);
      chk("R6 diff/chan", 64'(rd_data[22:19]), 64'(4'b1101));
      chk("R6 seq/aux/temp", 64'(rd_data[25:23]), 64'(3'b101));
      chk("R6 dio0/dio1", 64'(rd_data[27:26]), 64'(2'b10));
      chk("R2 count after lower", 64'(count), 64'd3);
      cyc(0, '0, '0, 1, 0, 1);
      chk("R2 count after upper", 64'(count), 64'd2);
      // R3: push with pop
      cyc(1, 30'h5, 30'h6, 1, 0, 0);
      cyc(1, 30'h7, 30'h8, 1, 0, 0);
      // R7: lower read then 64-bit read resets the half position
      cyc(0, '0, '0, 1, 0, 1);
      cyc(0, '0, '0, 0, 1, 1);
      cyc(0, '0, '0, 1, 0, 0);
      // R8: simultaneous requests
      dma_before = dma_data;
      cyc(0, '0, '0, 1, 1, 0);
      chk("R8 dma_data held", dma_data, dma_before);
      // drain and R4/R5 empty reads
      while (q.size() > 0) cyc(0, '0, '0, 0, 1, 0);
      cyc(0, '0, '0, 1, 0, 1);
      chk("R5 run bit set", 64'(rd_data[31:30]), 64'(2'b11));
      cyc(0, '0, '0, 1, 0, 0);
      chk("R4 invalid", 64'(rd_data), 64'h8000_0000);
      cyc(0, '0, '0, 0, 1, 1);
      // R9/R10: fill past full, threshold
      afull_level = CNT_W'(DEPTH - 2);
      for (int i = 0; i < DEPTH + 2; i++) cyc(1, 30'(i), 30'(i + 100), 0, 0, 0);
      cyc(1, 30'h1F, 30'h2F, 0, 1, 0);
      chk("R9 overflow sticky", 64'(overflow), 64'd1);
      // R11: random traffic, many wraps
      ok_tag = "R11";
      for (int i = 0; i < 4000; i++) begin
         afull_level = CNT_W'($urandom_range(0, DEPTH));
         cyc(($urandom & 3) != 0, 30'($urandom), 30'($urandom),
             ($urandom & 3) == 0, ($urandom & 7) == 0, 1'($urandom));
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule